// File: doc/BRIEF.md
# Cadenced Resonator Tone Generator with FSK

This block produces a digital sine tone from a two-pole recursive resonator. The resonator coefficient sets the pitch, and the value it is loaded with sets the amplitude. Two timers shape the tone into bursts. The on timer decides how many samples the tone sounds. The off timer then holds the output silent for its own count, and after that the resonator is reloaded and a new burst begins. Each timer has a sticky pending flag. A maskable interrupt output is the OR of the enabled flags.

A host configures the block through a small register port. Writes take effect at the next clock edge, and reads are combinational. A sample tick input sets the time base. In normal operation the resonator advances on every RATE_DIV-th tick, so a 24 kHz tick gives 8 kHz samples. When frequency-shift keying is enabled together with the generator, every tick is a sample, which gives finer resolution. In that mode, two parameter sets are held: a space set (bit 0) and a mark set (bit 1). The host only writes the next data bit. The bit currently sounding lasts for its own set's on time. When it ends, the resonator is reloaded from the set that the data bit then selects.

Top module: `tone_gen_top`

## Requirements
- R1: After reset, sample_o is 0, tone_on_o is 0, irq_o is 0, and every register reads 0.
- R2: Configuration registers read back what was written. The address map is:
  - 0: control. Bit 0 enables the generator. Bit 1 selects FSK.
  - 1: interrupt mask. Bit 0 is the on-timer flag. Bit 1 is the off-timer flag.
  - 2: pending flags, using the same bits as the mask.
  - 3: FSK data bit, in bit 0.
  - 4: off time.
  - 8, 9, 10: space-set coefficient, load value and on time.
  - 12, 13, 14: mark-set coefficient, load value and on time.
- R3: Each resonator step computes next = sat16(floor(coef*y1/2^13) - y2), then shifts y1 into y2. The output is y1. A load sets y1 = 0 and y2 = -load value. As a result, the first sample after a load is 0 and the next sample equals the load value.
- R4: With FSK off, the resonator steps on every third tick (RATE_DIV) counted from the start of a burst. With FSK on, it steps on every tick.
- R5: With FSK off and a non-zero off time, the tone sounds for on-time steps (a value of 0 counts as 1). The output is then 0 and tone_on_o is low for off-time steps. After that the resonator reloads and the tone sounds again.
- R6: An off time of 0 gives a continuous tone, and neither timer expires.
- R7: The pending flags are set when the on timer expires (bit 0) and when the off timer expires (bit 1). They hold until the host writes a 1 to that bit at address 2. A flag that is set in the same cycle as a clear stays set.
- R8: irq_o is high exactly when some pending flag is also enabled in the mask.
- R9: In FSK mode, the first bit uses the set selected by the data bit at enable. A data write in the middle of a bit does not change that bit. At bit end, the output restarts from a load of the newly selected set, and the on-timer flag is set.
- R10: A resonator result above 32767 gives 32767, and a result below -32768 gives -32768.
- R11: Clearing the enable returns the block to idle at the next edge, with sample_o at 0 and tone_on_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample-rate tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| sample_o | output | 16 | Signed tone sample, 0 when silent |
| tone_on_o | output | 1 | High while the tone is sounding |
| irq_o | output | 1 | Masked OR of pending flags |

## Verification
The bench builds the block with RATE_DIV = 3 and 16-bit timers. Timer values of two to four steps make full on/off cycles, reloads and flag setting happen within a few dozen ticks. This also keeps the skipped ticks of the divider visible. Coefficients of exactly +1.0 and -1.0 with a large load value drive the resonator into both saturation limits within two steps. In FSK mode, mark and space on times differ, so the bench can confirm from the output alone which set is sounding and when it switches.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int SMP_W     = 16;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 4;
  localparam int COEF_FRAC = 14;
  localparam int NSETS     = 2;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_IRQ_PEND = 4'd2;
  localparam logic [ADDR_W-1:0] A_FSK_BIT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_OFF_LEN  = 4'd4;
  localparam int SET_BASE   = 8;
  localparam int SET_STRIDE = 4;
  localparam int F_COEF     = 0;
  localparam int F_LOAD     = 1;
  localparam int F_ON       = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_e;

  function automatic logic [ADDR_W-1:0] set_addr(input int s, input int f);
    return ADDR_W'(SET_BASE + SET_STRIDE * s + f);
  endfunction

  // One resonator step: 2*cos(w)*y1 - y2, coefficient holds cos(w) in Q(COEF_FRAC)
  function automatic logic signed [SMP_W-1:0] res_next(
    input logic signed [SMP_W-1:0] coef,
    input logic signed [SMP_W-1:0] y1,
    input logic signed [SMP_W-1:0] y2);
    logic signed [2*SMP_W-1:0] prod;
    logic signed [2*SMP_W+1:0] acc;
    prod = coef * y1;
    acc  = (2*SMP_W+2)'(prod >>> (COEF_FRAC-1)) - (2*SMP_W+2)'(y2);
    if ((acc[2*SMP_W+1:SMP_W-1] == '0) || (acc[2*SMP_W+1:SMP_W-1] == '1))
      return acc[SMP_W-1:0];
    else if (acc[2*SMP_W+1])
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return {1'b0, {(SMP_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import tone_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic                              on_evt_i,
  input  logic                              off_evt_i,
  output logic                              gen_en_o,
  output logic                              fsk_en_o,
  output logic                              fsk_bit_o,
  output logic [CNT_W-1:0]                  off_len_o,
  output logic [NSETS-1:0][SMP_W-1:0]       coef_o,
  output logic [NSETS-1:0][SMP_W-1:0]       load_o,
  output logic [NSETS-1:0][CNT_W-1:0]       on_len_o,
  output logic                              irq_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam int NFLAG = 2;

  logic [1:0]       ctrl_q;
  logic [NFLAG-1:0] mask_q;
  logic [NFLAG-1:0] pend_q;
  logic [NFLAG-1:0] pend_clr;
  logic [NFLAG-1:0] pend_set;
  logic             bit_q;
  logic [CNT_W-1:0] off_q;

  assign pend_clr = (wr_en_i && addr_i == A_IRQ_PEND) ? wdata_i[NFLAG-1:0] : '0;
  assign pend_set = {off_evt_i, on_evt_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      bit_q  <= 1'b0;
      off_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      if (wr_en_i) begin
        if (addr_i == A_CTRL)     ctrl_q <= wdata_i[1:0];
        if (addr_i == A_IRQ_MASK) mask_q <= wdata_i[NFLAG-1:0];
        if (addr_i == A_FSK_BIT)  bit_q  <= wdata_i[0];
        if (addr_i == A_OFF_LEN)  off_q  <= wdata_i[CNT_W-1:0];
      end
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [SMP_W-1:0] coef_q;
    logic [SMP_W-1:0] load_q;
    logic [CNT_W-1:0] on_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_q <= '0;
        load_q <= '0;
        on_q   <= '0;
      end else if (wr_en_i) begin
        if (addr_i == set_addr(s, F_COEF)) coef_q <= wdata_i[SMP_W-1:0];
        if (addr_i == set_addr(s, F_LOAD)) load_q <= wdata_i[SMP_W-1:0];
        if (addr_i == set_addr(s, F_ON))   on_q   <= wdata_i[CNT_W-1:0];
      end
    end
    assign coef_o[s]   = coef_q;
    assign load_o[s]   = load_q;
    assign on_len_o[s] = on_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:     rdata_o[1:0]       = ctrl_q;
      A_IRQ_MASK: rdata_o[NFLAG-1:0] = mask_q;
      A_IRQ_PEND: rdata_o[NFLAG-1:0] = pend_q;
      A_FSK_BIT:  rdata_o[0]         = bit_q;
      A_OFF_LEN:  rdata_o[CNT_W-1:0] = off_q;
      default:    rdata_o            = '0;
    endcase
    for (int s = 0; s < NSETS; s++) begin
      if (addr_i == set_addr(s, F_COEF)) rdata_o = DATA_W'(coef_o[s]);
      if (addr_i == set_addr(s, F_LOAD)) rdata_o = DATA_W'(load_o[s]);
      if (addr_i == set_addr(s, F_ON))   rdata_o = DATA_W'(on_len_o[s]);
    end
  end

  assign gen_en_o  = ctrl_q[0];
  assign fsk_en_o  = ctrl_q[1];
  assign fsk_bit_o = bit_q;
  assign off_len_o = off_q;
  assign irq_o     = |(pend_q & mask_q);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt_i |=> pend_q[0]);
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[1] && !(wr_en_i && addr_i == A_IRQ_PEND && wdata_i[1])) |=> pend_q[1]);
endmodule

// File: rtl/tone_cadence.sv
module tone_cadence
  import tone_pkg::*;
#(
  parameter int RATE_DIV = 3,
  parameter int CNT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic                        gen_en_i,
  input  logic                        fsk_en_i,
  input  logic                        fsk_bit_i,
  input  logic [CNT_W-1:0]            off_len_i,
  input  logic [NSETS-1:0][CNT_W-1:0] on_len_i,
  output logic                        load_o,
  output logic                        load_set_o,
  output logic                        adv_o,
  output logic                        cur_set_o,
  output logic                        tone_on_o,
  output logic                        on_evt_o,
  output logic                        off_evt_o
);
  localparam int DIV_W = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             set_q;

  logic             start;
  logic             step;
  logic             timed_on;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   len_on;
  logic [CNT_W:0]   len_off;

  assign start    = gen_en_i && (phase_q == PH_IDLE);
  assign step     = tick_i && gen_en_i && (phase_q != PH_IDLE) &&
                    (fsk_en_i || div_q == DIV_W'(RATE_DIV-1));
  assign timed_on = fsk_en_i || (off_len_i != '0);
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign len_on   = (on_len_i[set_q] == '0) ? (CNT_W+1)'(1) : {1'b0, on_len_i[set_q]};
  assign len_off  = (off_len_i == '0) ? (CNT_W+1)'(1) : {1'b0, off_len_i};

  assign on_evt_o   = step && (phase_q == PH_ON) && timed_on && (cnt_inc >= len_on);
  assign off_evt_o  = step && (phase_q == PH_OFF) && (cnt_inc >= len_off);
  assign load_set_o = fsk_en_i ? fsk_bit_i : 1'b0;
  assign load_o     = start || off_evt_o || (on_evt_o && fsk_en_i);
  assign adv_o      = step && (phase_q == PH_ON) && !on_evt_o;
  assign cur_set_o  = set_q;
  assign tone_on_o  = (phase_q == PH_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
      set_q   <= 1'b0;
    end else if (!gen_en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
      set_q   <= 1'b0;
    end else if (start) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
      div_q   <= '0;
      set_q   <= load_set_o;
    end else begin
      if (tick_i && !fsk_en_i)
        div_q <= (div_q == DIV_W'(RATE_DIV-1)) ? '0 : div_q + 1'b1;
      if (step) begin
        if (phase_q == PH_ON) begin
          if (on_evt_o) begin
            cnt_q <= '0;
            if (fsk_en_i) set_q   <= load_set_o;
            else          phase_q <= PH_OFF;
          end else if (timed_on) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (off_evt_o) begin
          phase_q <= PH_ON;
          cnt_q   <= '0;
          set_q   <= load_set_o;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_on_end_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_evt_o && !fsk_en_i) |=> !tone_on_o);
  p_off_end_sound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt_o |=> tone_on_o);
  p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o || on_evt_o || off_evt_o) |-> tick_i);
  p_continuous_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsk_en_i && off_len_i == '0 && tone_on_o) |-> !on_evt_o);
  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_i |=> !tone_on_o);
  p_fsk_stays_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsk_en_i && gen_en_i && tone_on_o) |=> (tone_on_o || !$past(gen_en_i) ||
                                              !$past(fsk_en_i)));
endmodule

// File: rtl/tone_resonator.sv
module tone_resonator
  import tone_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    adv_i,
  input  logic signed [SMP_W-1:0] coef_i,
  input  logic signed [SMP_W-1:0] load_val_i,
  output logic signed [SMP_W-1:0] y_o
);
  logic signed [SMP_W-1:0] y1_q;
  logic signed [SMP_W-1:0] y2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1_q <= '0;
      y2_q <= '0;
    end else if (load_i) begin
      y1_q <= '0;
      y2_q <= -load_val_i;
    end else if (adv_i) begin
      y1_q <= res_next(coef_i, y1_q, y2_q);
      y2_q <= y1_q;
    end
  end

  assign y_o = y1_q;

  p_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (y1_q == '0));
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (y2_q == $past(y1_q)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(y1_q));
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tone_pkg::*;
#(
  parameter int RATE_DIV = 3,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic signed [15:0] sample_o,
  output logic              tone_on_o,
  output logic              irq_o
);
  logic                        gen_en, fsk_en, fsk_bit;
  logic [CNT_W-1:0]            off_len;
  logic [NSETS-1:0][SMP_W-1:0] coef, load_val;
  logic [NSETS-1:0][CNT_W-1:0] on_len;
  logic                        on_evt, off_evt;
  logic                        load, load_set, adv, cur_set, tone_on;
  logic signed [SMP_W-1:0]     res_y;

  tone_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .on_evt_i(on_evt), .off_evt_i(off_evt),
    .gen_en_o(gen_en), .fsk_en_o(fsk_en), .fsk_bit_o(fsk_bit),
    .off_len_o(off_len), .coef_o(coef), .load_o(load_val),
    .on_len_o(on_len), .irq_o(irq_o), .rdata_o(rdata_o));

  tone_cadence #(.RATE_DIV(RATE_DIV), .CNT_W(CNT_W)) u_cad (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gen_en_i(gen_en),
    .fsk_en_i(fsk_en), .fsk_bit_i(fsk_bit), .off_len_i(off_len),
    .on_len_i(on_len), .load_o(load), .load_set_o(load_set), .adv_o(adv),
    .cur_set_o(cur_set), .tone_on_o(tone_on), .on_evt_o(on_evt),
    .off_evt_o(off_evt));

  tone_resonator u_res (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .coef_i(coef[cur_set]), .load_val_i(load_val[load_set]), .y_o(res_y));

  assign tone_on_o = tone_on;
  assign sample_o  = tone_on ? res_y : '0;

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(on_evt) || $past(off_evt) ||
                      $past(wr_en_i) || $past(irq_o)));
endmodule

// File: tb/tb_tone_gen_top.sv
module tb_tone_gen_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [3:0]        addr_i = '0;
  logic [15:0]       wdata_i = '0;
  logic [15:0]       rdata_o;
  logic signed [15:0] sample_o;
  logic              tone_on_o;
  logic              irq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int my1, my2, mcoef;

  always #5 clk = ~clk;

  tone_gen_top #(.RATE_DIV(3), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sample_o(sample_o), .tone_on_o(tone_on_o), .irq_o(irq_o));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // floor-divided product, minus older sample, clamped to 16 bits
  function automatic int model_next(input int c, input int a, input int b);
    longint p, q, r;
    p = longint'(c) * longint'(a);
    q = p / 8192;
    if (p < 0 && (p % 8192) != 0) q = q - 1;
    r = q - longint'(b);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic m_load(input int c, input int v);
    my1 = 0; my2 = -v; mcoef = c;
  endtask

  task automatic m_step();
    int n;
    n = model_next(mcoef, my1, my2);
    my2 = my1; my1 = n;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 4'(a); wdata_i = 16'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output int d);
    addr_i = 4'(a);
    #1;
    d = int'(rdata_o);
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic nstep();
    tick(); tick(); tick();
  endtask

  task automatic stop_all();
    wr(0, 0);
    wr(2, 3);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 sample", int'(sample_o), 0);
    chk("R1 tone_on", int'(tone_on_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rd(0, v);  chk("R1 ctrl", v, 0);
    rd(2, v);  chk("R1 pend", v, 0);
    rd(10, v); chk("R1 on0", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(12, 16'hA5C3); rd(12, v); chk("R2 coef1", v, 16'hA5C3);
    wr(13, 1234);     rd(13, v); chk("R2 load1", v, 1234);
    wr(14, 777);      rd(14, v); chk("R2 on1", v, 777);
    wr(4, 16'hFFFF);  rd(4, v);  chk("R2 off", v, 16'hFFFF);
    wr(1, 2);         rd(1, v);  chk("R2 mask", v, 2);
    wr(3, 1);         rd(3, v);  chk("R2 fsk bit", v, 1);
    wr(1, 0); wr(3, 0);
  endtask

  task automatic t_cadence();
    int v;
    wr(8, 11585); wr(9, 8000); wr(10, 4); wr(4, 2);
    wr(0, 1);
    chk("R5 start on", int'(tone_on_o), 1);
    chk("R3 first sample zero", int'(sample_o), 0);
    m_load(11585, 8000);
    tick();
    chk("R4 no step after one tick", int'(sample_o), 0);
    tick(); tick(); m_step();
    chk("R3 sample1 equals load", int'(sample_o), 8000);
    for (int k = 0; k < 2; k++) begin
      nstep(); m_step();
      chk("R3 burst sample", int'(sample_o), my1);
    end
    nstep();
    chk("R5 off after on time", int'(tone_on_o), 0);
    chk("R5 silent", int'(sample_o), 0);
    rd(2, v); chk("R7 on flag", v, 1);
    nstep();
    chk("R5 still off", int'(tone_on_o), 0);
    nstep();
    chk("R5 back on", int'(tone_on_o), 1);
    chk("R3 reload zero", int'(sample_o), 0);
    rd(2, v); chk("R7 off flag", v, 3);
    m_load(11585, 8000);
    nstep(); m_step();
    chk("R5 new burst sample", int'(sample_o), my1);
    wr(0, 0);
    chk("R11 idle tone_on", int'(tone_on_o), 0);
    chk("R11 idle sample", int'(sample_o), 0);
  endtask

  task automatic t_irq();
    int v;
    chk("R8 masked", int'(irq_o), 0);
    wr(1, 2);
    chk("R8 off flag enabled", int'(irq_o), 1);
    wr(2, 2);
    chk("R8 cleared enabled flag", int'(irq_o), 0);
    rd(2, v); chk("R7 only bit1 cleared", v, 1);
    wr(2, 1);
    rd(2, v); chk("R7 all cleared", v, 0);
    wr(1, 0);
  endtask

  task automatic t_continuous();
    int v;
    wr(8, 9000); wr(9, 6000); wr(10, 2); wr(4, 0);
    wr(0, 1);
    m_load(9000, 6000);
    for (int k = 0; k < 6; k++) begin
      nstep(); m_step();
      chk("R6 continuous sample", int'(sample_o), my1);
    end
    chk("R6 still on", int'(tone_on_o), 1);
    rd(2, v); chk("R6 no flags", v, 0);
    stop_all();
  endtask

  task automatic t_saturate();
    wr(8, 16384); wr(9, 30000); wr(4, 0);
    wr(0, 1);
    nstep(); chk("R10 first", int'(sample_o), 30000);
    nstep(); chk("R10 positive clamp", int'(sample_o), 32767);
    wr(0, 0);
    wr(8, 16'hC000);
    wr(0, 1);
    nstep(); chk("R10 first neg", int'(sample_o), 30000);
    nstep(); chk("R10 negative clamp", int'(sample_o), -32768);
    stop_all();
  endtask

  task automatic t_fsk();
    int v;
    wr(8, 8000); wr(9, 5000); wr(10, 2);
    wr(12, 16'hF448); wr(13, 7000); wr(14, 3);
    wr(3, 1);
    wr(0, 3);
    chk("R9 start on", int'(tone_on_o), 1);
    m_load(-3000, 7000);
    tick(); m_step();
    chk("R4 fsk step each tick", int'(sample_o), 7000);
    wr(3, 0);
    tick(); m_step();
    chk("R9 mark kept mid-bit", int'(sample_o), my1);
    tick();
    chk("R9 reload at bit end", int'(sample_o), 0);
    rd(2, v); chk("R9 bit-end flag", v, 1);
    tick();
    chk("R9 space sample", int'(sample_o), 5000);
    tick();
    chk("R9 space bit two ticks", int'(sample_o), 0);
    wr(3, 1);
    tick();
    chk("R9 space still sounding", int'(sample_o), 5000);
    tick();
    chk("R9 mark reload", int'(sample_o), 0);
    tick();
    chk("R9 mark sample", int'(sample_o), 7000);
    stop_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_cadence();
    t_irq();
    t_continuous();
    t_saturate();
    t_fsk();
    finish_run();
  end
endmodule